// File: doc/BRIEF.md
# Parallel Byte Loader for a Frequency Synthesizer

This block sits on the host side of a link to a direct digital synthesizer that accepts its 40-bit control word as five bytes over an 8-bit parallel bus. On a start request it captures the full word. It then places each byte on the bus and strobes a write clock once per byte. When all five bytes are written, it raises a commit strobe so the synthesizer acts on the new word and rewinds its internal byte pointer.

The word is split into a leading control byte, which carries phase and control bits, and a 32-bit frequency tuning word that follows most significant byte first. A start request may optionally ask for a device reset pulse first. This is meant for power-up, before the first word reaches the device.

Setup time, hold time and the widths of the write strobe, the commit strobe and the reset strobe are all counted in system clock cycles and set by parameters. A busy flag covers the whole transfer, and a one-cycle done pulse marks its end.

Top module: `pword_writer`

## Requirements
- R1: Bytes go out in a fixed order. The first is cfg_word_i[39:32] (control/phase byte), then [31:24], [23:16], [15:8], and last [7:0].
- R2: Each accepted start produces exactly five rising edges of wclk_o. After the fifth write strobe has fallen, exactly one fqud_o pulse follows. wclk_o and fqud_o are never high together.
- R3: bus_data_o holds its value for at least SETUP_CYC cycles with wclk_o low before each wclk_o rising edge. It does not change while wclk_o is high, and it stays unchanged for HOLD_CYC cycles after wclk_o falls.
- R4: Every wclk_o pulse is high for exactly WCLK_HI_CYC cycles, every fqud_o pulse for exactly COMMIT_CYC cycles, and every dev_rst_o pulse for exactly RST_CYC cycles. Outside these pulses the three strobes are low.
- R5: A start with rst_first_i high issues one dev_rst_o pulse that ends before the first byte's setup begins. A start with rst_first_i low issues no dev_rst_o pulse. dev_rst_o is never high together with wclk_o or fqud_o.
- R6: busy_o is high from the cycle after an accepted start until the cycle in which fqud_o falls. In that cycle busy_o is low and done_o is high, and done_o lasts exactly one cycle.
- R7: start_i is ignored while busy_o is high. It produces no extra bytes, strobes or reset pulses.
- R8: The word is captured in the cycle start is accepted. Changing cfg_word_i during a transfer does not alter the bytes sent.
- R9: While rst_n is low, all outputs are held at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request to send one word (accepted only when idle) |
| rst_first_i | input | 1 | With start, pulse the device reset before the bytes |
| cfg_word_i | input | 40 | Control byte [39:32] and frequency word [31:0] |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle pulse at end of transfer |
| bus_data_o | output | 8 | Parallel byte bus to the device |
| wclk_o | output | 1 | Byte write strobe, device latches on rising edge |
| fqud_o | output | 1 | Commit strobe, rising edge applies the word |
| dev_rst_o | output | 1 | Device reset strobe |

## Verification
Every byte is compared against a queue filled from the requested word, in order. A reversed or mis-sliced byte mapping therefore shows up as a mismatched value. A sixth write strobe or a missing one shows up as an empty queue or a wrong count at the commit edge.

Setup and hold are measured by counting the cycles for which the bus stays steady around each strobe edge. This catches a design that updates the data together with the strobe or one cycle too early.

Start requests are injected in the middle of a transfer, with the input word scrambled and the reset flag set. A design that re-arms while busy, or reads the live input instead of a captured copy, would emit extra or corrupted bytes and an unexpected reset pulse.

The end of each transfer is checked for busy falling exactly as done rises and the commit strobe drops. An off-by-one state machine would break that alignment.

// File: rtl/pww_pkg.sv
package pww_pkg;

    localparam int NUM_BYTES = 5;
    localparam int BUS_W     = 8;
    localparam int WORD_W    = NUM_BYTES * BUS_W;
    localparam int IDX_W     = $clog2(NUM_BYTES);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RST,
        ST_SETUP,
        ST_WHI,
        ST_HOLD,
        ST_COMMIT
    } pww_state_e;

    function automatic int max_of5(input int a, input int b, input int c,
                                   input int d, input int e);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        if (e > m) m = e;
        return m;
    endfunction

endpackage

// File: rtl/pww_byte_sel.sv
module pww_byte_sel
    import pww_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic [BUS_W-1:0]  byte_o
);

    logic [BUS_W-1:0] slices [NUM_BYTES];

    // slice 0 is the most significant byte of the word, sent first
    for (genvar k = 0; k < NUM_BYTES; k++) begin : g_slice
        assign slices[k] = word_i[WORD_W-1-k*BUS_W -: BUS_W];
    end

    always_comb begin
        byte_o = '0;
        for (int k = 0; k < NUM_BYTES; k++) begin
            if (idx_i == IDX_W'(k)) byte_o = slices[k];
        end
    end

endmodule

// File: rtl/pww_phase_timer.sv
module pww_phase_timer
    import pww_pkg::*;
#(
    parameter int CNT_W       = 3,
    parameter int RST_CYC     = 4,
    parameter int SETUP_CYC   = 2,
    parameter int WCLK_HI_CYC = 2,
    parameter int HOLD_CYC    = 1,
    parameter int COMMIT_CYC  = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_i,
    input  pww_state_e state_i,
    output logic       expired_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] len_m1;

    always_comb begin
        unique case (state_i)
            ST_RST:    len_m1 = CNT_W'(RST_CYC - 1);
            ST_SETUP:  len_m1 = CNT_W'(SETUP_CYC - 1);
            ST_WHI:    len_m1 = CNT_W'(WCLK_HI_CYC - 1);
            ST_HOLD:   len_m1 = CNT_W'(HOLD_CYC - 1);
            ST_COMMIT: len_m1 = CNT_W'(COMMIT_CYC - 1);
            default:   len_m1 = '0;
        endcase
    end

    always_comb begin
        if (load_i)
            cnt_d = len_m1;
        else if (cnt_q != '0)
            cnt_d = cnt_q - CNT_W'(1);
        else
            cnt_d = cnt_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/pword_writer.sv
module pword_writer
    import pww_pkg::*;
#(
    parameter int RST_CYC     = 4,
    parameter int SETUP_CYC   = 2,
    parameter int WCLK_HI_CYC = 2,
    parameter int HOLD_CYC    = 1,
    parameter int COMMIT_CYC  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              rst_first_i,
    input  logic [WORD_W-1:0] cfg_word_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [BUS_W-1:0]  bus_data_o,
    output logic              wclk_o,
    output logic              fqud_o,
    output logic              dev_rst_o
);

    localparam int MAX_LEN = max_of5(RST_CYC, SETUP_CYC, WCLK_HI_CYC, HOLD_CYC, COMMIT_CYC);
    localparam int CNT_W   = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BYTES - 1);

    typedef struct packed {
        pww_state_e         state;
        logic [IDX_W-1:0]   idx;
        logic [WORD_W-1:0]  word;
        logic [BUS_W-1:0]   data;
        logic               wclk;
        logic               fqud;
        logic               devrst;
        logic               busy;
        logic               done;
    } regs_t;

    regs_t d, q;

    logic              tmr_load;
    pww_state_e        tmr_state;
    logic              tmr_expired;
    logic [WORD_W-1:0] src_word;
    logic [IDX_W-1:0]  src_idx;
    logic [BUS_W-1:0]  sel_byte;

    // byte source: the live input while idle (first byte), the captured copy after
    always_comb begin
        src_word = (q.state == ST_IDLE) ? cfg_word_i : q.word;
        src_idx  = (q.state == ST_HOLD) ? q.idx + IDX_W'(1) : q.idx;
        if (q.state == ST_IDLE) src_idx = '0;
    end

    pww_byte_sel u_sel (
        .word_i (src_word),
        .idx_i  (src_idx),
        .byte_o (sel_byte)
    );

    pww_phase_timer #(
        .CNT_W       (CNT_W),
        .RST_CYC     (RST_CYC),
        .SETUP_CYC   (SETUP_CYC),
        .WCLK_HI_CYC (WCLK_HI_CYC),
        .HOLD_CYC    (HOLD_CYC),
        .COMMIT_CYC  (COMMIT_CYC)
    ) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (tmr_load),
        .state_i   (tmr_state),
        .expired_o (tmr_expired)
    );

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        tmr_load  = 1'b0;
        tmr_state = ST_IDLE;

        unique case (q.state)
            ST_IDLE: begin
                if (start_i) begin
                    d.word   = cfg_word_i;
                    d.idx    = '0;
                    d.busy   = 1'b1;
                    tmr_load = 1'b1;
                    if (rst_first_i) begin
                        d.state   = ST_RST;
                        d.devrst  = 1'b1;
                        tmr_state = ST_RST;
                    end else begin
                        d.state   = ST_SETUP;
                        d.data    = sel_byte;
                        tmr_state = ST_SETUP;
                    end
                end
            end
            ST_RST: begin
                if (tmr_expired) begin
                    d.devrst  = 1'b0;
                    d.state   = ST_SETUP;
                    d.data    = sel_byte;
                    tmr_load  = 1'b1;
                    tmr_state = ST_SETUP;
                end
            end
            ST_SETUP: begin
                if (tmr_expired) begin
                    d.wclk    = 1'b1;
                    d.state   = ST_WHI;
                    tmr_load  = 1'b1;
                    tmr_state = ST_WHI;
                end
            end
            ST_WHI: begin
                if (tmr_expired) begin
                    d.wclk    = 1'b0;
                    d.state   = ST_HOLD;
                    tmr_load  = 1'b1;
                    tmr_state = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (tmr_expired) begin
                    tmr_load = 1'b1;
                    if (q.idx == LAST_IDX) begin
                        d.fqud    = 1'b1;
                        d.state   = ST_COMMIT;
                        tmr_state = ST_COMMIT;
                    end else begin
                        d.idx     = src_idx;
                        d.data    = sel_byte;
                        d.state   = ST_SETUP;
                        tmr_state = ST_SETUP;
                    end
                end
            end
            ST_COMMIT: begin
                if (tmr_expired) begin
                    d.fqud  = 1'b0;
                    d.busy  = 1'b0;
                    d.done  = 1'b1;
                    d.state = ST_IDLE;
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{state: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign busy_o     = q.busy;
    assign done_o     = q.done;
    assign bus_data_o = q.data;
    assign wclk_o     = q.wclk;
    assign fqud_o     = q.fqud;
    assign dev_rst_o  = q.devrst;

endmodule

// File: rtl/pww_chk.sv
module pww_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy_o,
    input logic       done_o,
    input logic [7:0] bus_data_o,
    input logic       wclk_o,
    input logic       fqud_o,
    input logic       dev_rst_o
);

    // R2
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wclk_o && fqud_o));

    // R5
    rst_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dev_rst_o |-> !(wclk_o || fqud_o));

    // R3
    setup_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wclk_o) |-> $stable(bus_data_o));

    // R3
    hold_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wclk_o |=> $stable(bus_data_o));

    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R6
    done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $fell(fqud_o)));

    // R6
    strobe_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wclk_o || fqud_o || dev_rst_o) |-> busy_o);

endmodule

bind pword_writer pww_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .bus_data_o (bus_data_o),
    .wclk_o     (wclk_o),
    .fqud_o     (fqud_o),
    .dev_rst_o  (dev_rst_o)
);

// File: tb/sim_pword_writer.sv
`timescale 1ns/1ps
module sim_pword_writer;

    localparam int RST_C   = 4;
    localparam int SETUP_C = 2;
    localparam int WHI_C   = 2;
    localparam int HOLD_C  = 1;
    localparam int FQ_C    = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        rst_first = 1'b0;
    logic [39:0] cfg = '0;
    logic        busy, done, wclk, fqud, drst;
    logic [7:0]  data;

    int tests = 0;
    int fails = 0;
    int exp_rst = 0;
    int seen_rst = 0;
    bit mon_en = 1'b0;
    logic [7:0] exp_q [$];

    always #4 clk = ~clk;

    pword_writer #(
        .RST_CYC(RST_C), .SETUP_CYC(SETUP_C), .WCLK_HI_CYC(WHI_C),
        .HOLD_CYC(HOLD_C), .COMMIT_CYC(FQ_C)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .rst_first_i(rst_first),
        .cfg_word_i(cfg), .busy_o(busy), .done_o(done), .bus_data_o(data),
        .wclk_o(wclk), .fqud_o(fqud), .dev_rst_o(drst)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // monitor: pops expected bytes and times every strobe
    logic [7:0] prev_data = '0;
    bit prev_w = 0, prev_f = 0, prev_r = 0, prev_done = 0;
    int stable_cnt = 0, since_fall = 0, w_hi = 0, f_hi = 0, r_hi = 0, byte_cnt = 0;

    always @(negedge clk) begin
        if (mon_en) begin
            if (!wclk && prev_w) since_fall = 1;
            else if (since_fall > 0 && since_fall < 1000) since_fall++;

            if (data !== prev_data) begin
                if ((since_fall > 0 && since_fall <= HOLD_C) || wclk)
                    chk(0, "R3 hold violated", since_fall, HOLD_C + 1);
                stable_cnt = 1;
            end else begin
                stable_cnt++;
            end

            if (wclk && !prev_w) begin
                chk(stable_cnt >= SETUP_C + 1, "R3 setup", stable_cnt, SETUP_C + 1);
                chk(!drst, "R5 reset overlaps write", drst, 0);
                if (exp_q.size() == 0) begin
                    chk(0, "R7 unexpected byte", data, 0);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    chk(data == e, "R1 byte value", data, e);
                end
                byte_cnt++;
                w_hi = 1;
            end else if (wclk) begin
                w_hi++;
            end
            if (!wclk && prev_w) chk(w_hi == WHI_C, "R4 wclk width", w_hi, WHI_C);

            if (fqud && !prev_f) begin
                chk(byte_cnt == 5 && !wclk, "R2 five bytes before commit", byte_cnt, 5);
                byte_cnt = 0;
                f_hi = 1;
            end else if (fqud) begin
                f_hi++;
            end
            if (!fqud && prev_f) begin
                chk(f_hi == FQ_C, "R4 fqud width", f_hi, FQ_C);
                chk(!busy && done, "R6 end alignment", {busy, done}, 2'b01);
            end

            if (drst && !prev_r) begin
                seen_rst++;
                chk(byte_cnt == 0, "R5 reset before first byte", byte_cnt, 0);
                r_hi = 1;
            end else if (drst) begin
                r_hi++;
            end
            if (!drst && prev_r) chk(r_hi == RST_C, "R4 reset width", r_hi, RST_C);

            if (done && (prev_done || !prev_f)) chk(0, "R6 done pulse", done, 0);
            if ((wclk || fqud || drst) && !busy) chk(0, "R6 busy during strobe", busy, 1);

            prev_w = wclk; prev_f = fqud; prev_r = drst;
            prev_done = done; prev_data = data;
        end
    end

    task automatic send(input logic [39:0] w, input bit rf, input bit glitch);
        while (busy) @(negedge clk);
        for (int k = 0; k < 5; k++) exp_q.push_back(w[39-8*k -: 8]);
        if (rf) exp_rst++;
        cfg = w; rst_first = rf; start = 1'b1;
        @(negedge clk);
        chk(busy == 1'b1, "R6 busy after start", busy, 1);
        start = 1'b0; rst_first = 1'b0;
        cfg = ~w;   // R8: input changes after capture
        if (glitch) begin
            repeat (3) @(negedge clk);
            // R7: start while busy must be ignored
            cfg = 40'hDE_AD_BE_EF_77; rst_first = 1'b1; start = 1'b1;
            repeat (2) @(negedge clk);
            start = 1'b0; rst_first = 1'b0;
        end
        while (!done) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9: outputs held at zero in reset
        chk({busy, done, data, wclk, fqud, drst} == '0, "R9 reset state",
            {busy, done, data, wclk, fqud, drst}, 0);
        rst_n = 1'b1;
        mon_en = 1'b1;
        @(negedge clk);

        send(40'h01_0A_AA_AA_AA, 1'b0, 1'b0);
        send(40'hFF_00_FF_00_5A, 1'b1, 1'b0);
        send(40'h00_00_00_00_00, 1'b0, 1'b1);
        send(40'h12_34_56_78_9A, 1'b1, 1'b1);
        send(40'h80_01_02_03_C4, 1'b0, 1'b0);

        repeat (40) @(negedge clk);
        chk(exp_q.size() == 0, "R2 all bytes sent", exp_q.size(), 0);
        chk(seen_rst == exp_rst, "R5 reset pulse count", seen_rst, exp_rst);
        chk(!busy && !wclk && !fqud && !drst, "R7 idle after stray start",
            {busy, wclk, fqud, drst}, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL R6 watchdog: actual busy=%0d expected transfer to finish", busy);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule